// File: doc/BRIEF.md
# SPI Page-Write Loader

This block sits behind the serial pins of a nonvolatile memory and handles the page-write command. It watches chip select, serial clock and serial data, all oversampled by a fast core clock. When the command byte equals the write code, it collects a two-byte address. It then places each following data byte into a page-sized staging buffer. The storage array, its programming time and any protection rules sit outside this block.

The low address bits select the starting byte inside the page. After each byte, only those low bits advance, so a long burst folds back to the start of the same page and overwrites earlier bytes. The block keeps a per-byte flag for every slot that was loaded. When chip select is released, it raises a single-cycle commit strobe carrying the page number, the flag mask and the buffer contents. The strobe is suppressed when no whole data byte arrived or when the release cut a byte short. The serial output driver is never enabled during this command.

Top module: `spiw_front`

## Requirements
- R1: After reset, `commit_valid` and `so_oe` are low, and no commit occurs until a complete write sequence has ended.
- R2: Only a first byte of 8'h02, received MSB first, starts a write. A sequence whose first byte is any other value produces no commit.
- R3: The 16 bits after the command form the address, MSB first. Bit 15 is ignored. `commit_page` equals address bits 14..6, and it stays fixed while data bytes are loading.
- R4: The first data byte is stored at offset address[5:0]. Each later byte goes to the previous offset plus one. Data bits are received MSB first and sampled on the rising edge of SCK.
- R5: The offset after 63 is 0 within the same page. A byte loaded to an offset that is already filled replaces the earlier value.
- R6: Bit i of `commit_mask` is 1 exactly when a byte was loaded at offset i during the sequence. Byte i of `commit_data` is `commit_data[8*i+7:8*i]`.
- R7: `commit_valid` is high for exactly one core clock. It goes high within 4 core clocks after `cs_n` rises, and never while `cs_n` stays low.
- R8: No commit is issued if `cs_n` rises before the first data byte is complete, or while a byte is partly shifted in.
- R9: `so_oe` stays low at all times, so SO is high impedance throughout.
- R10: Both clock polarities are accepted: SCK idling low (mode 0) and SCK idling high (mode 3).
- R11: While `cs_n` is high, the bit count and the command decoder return to their start state. A sequence aborted partway therefore has no effect on the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host (driven only when `so_oe` is high) |
| so_oe | output | 1 | Output enable for SO, always low here |
| commit_valid | output | 1 | Single-cycle program request |
| commit_page | output | 9 | Page number, address bits 14..6 |
| commit_mask | output | 64 | One bit per loaded byte slot |
| commit_data | output | 512 | Page buffer, byte i at bits 8*i+7..8*i |

## Verification
The hardest case is a burst that runs past the end of the page. Reaching it needs more than 64 data bytes, so the fold-back to offset 0 overwrites slots that were filled earlier in the same sequence. The bench sends 70 bytes starting mid-page and checks that the first six slots reached hold the last six bytes. Chip-select releases that land mid-byte, mid-command and right after the address are produced by cutting the bit stream at a chosen bit count. Each cut is followed by a clean sequence, which shows that no state carries over from the aborted one.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

  localparam int unsigned PAGE_BYTES_DEF = 64;
  localparam int unsigned USED_BITS_DEF  = 15;
  localparam logic [7:0]  WRITE_CODE     = 8'h02;

  typedef enum logic [2:0] {
    DEC_OPCODE  = 3'd0,
    DEC_ADDR_HI = 3'd1,
    DEC_ADDR_LO = 3'd2,
    DEC_LOAD    = 3'd3,
    DEC_SKIP    = 3'd4
  } dec_state_t;

  function automatic logic is_write(input logic [7:0] code);
    return code == WRITE_CODE;
  endfunction

  // Offset advance that folds back inside the page
  function automatic logic [15:0] next_off(input logic [15:0] off, input int unsigned ow);
    return (off + 16'd1) & ((16'd1 << ow) - 16'd1);
  endfunction

  // Page number: keep the used bits, drop the in-page offset
  function automatic logic [15:0] page_of(input logic [15:0] addr, input int unsigned used,
                                          input int unsigned ow);
    return (addr & ((16'd1 << used) - 16'd1)) >> ow;
  endfunction

endpackage

// File: rtl/spiw_edge.sv
module spiw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic s_si,
  output logic sck_rise,
  output logic cs_rise,
  output logic cs_idle
);
  logic sck_q, sck_p, cs_q, cs_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sck_p <= 1'b0;
      cs_q  <= 1'b1;
      cs_p  <= 1'b1;
      s_si  <= 1'b0;
    end else begin
      sck_q <= sck;
      sck_p <= sck_q;
      cs_q  <= cs_n;
      cs_p  <= cs_q;
      s_si  <= si;
    end
  end

  assign sck_rise = sck_q & ~sck_p & ~cs_q;
  assign cs_rise  = cs_q & ~cs_p;
  assign cs_idle  = cs_q;
endmodule

// File: rtl/spiw_shift.sv
module spiw_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_idle,
  input  logic       sck_rise,
  input  logic       s_si,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output logic       mid_byte
);
  logic [2:0] bit_cnt;
  logic [6:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      sh        <= '0;
      byte_done <= 1'b0;
      byte_val  <= '0;
    end else begin
      byte_done <= 1'b0;
      if (cs_idle) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        sh      <= {sh[5:0], s_si};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          byte_val  <= {sh, s_si};
        end
      end
    end
  end

  assign mid_byte = (bit_cnt != 3'd0);
endmodule

// File: rtl/spiw_decode.sv
module spiw_decode
  import spiw_pkg::*;
#(
  parameter int unsigned USED_BITS = USED_BITS_DEF,
  parameter int unsigned OFF_W     = 6,
  parameter int unsigned PAGE_W    = USED_BITS - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_idle,
  input  logic              cs_rise,
  input  logic              byte_done,
  input  logic [7:0]        byte_val,
  input  logic              mid_byte,
  input  logic              any_loaded,
  output dec_state_t        state,
  output logic              seq_start,
  output logic              off_load,
  output logic [OFF_W-1:0]  off_val,
  output logic              data_store,
  output logic [PAGE_W-1:0] page,
  output logic              commit_valid
);
  logic [7:0]  addr_hi;
  logic [15:0] full_addr;

  assign full_addr  = {addr_hi, byte_val};
  assign off_val    = OFF_W'(full_addr);
  assign seq_start  = byte_done && !cs_idle && (state == DEC_OPCODE) && is_write(byte_val);
  assign off_load   = byte_done && !cs_idle && (state == DEC_ADDR_LO);
  assign data_store = byte_done && !cs_idle && (state == DEC_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= DEC_OPCODE;
      addr_hi      <= '0;
      page         <= '0;
      commit_valid <= 1'b0;
    end else begin
      commit_valid <= cs_rise && (state == DEC_LOAD) && !mid_byte && any_loaded;
      if (cs_idle) begin
        state <= DEC_OPCODE;
      end else if (byte_done) begin
        case (state)
          DEC_OPCODE:  state <= is_write(byte_val) ? DEC_ADDR_HI : DEC_SKIP;
          DEC_ADDR_HI: begin
            addr_hi <= byte_val;
            state   <= DEC_ADDR_LO;
          end
          DEC_ADDR_LO: begin
            page  <= PAGE_W'(page_of(full_addr, USED_BITS, OFF_W));
            state <= DEC_LOAD;
          end
          default:     state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/spiw_pagebuf.sv
module spiw_pagebuf
  import spiw_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = PAGE_BYTES_DEF,
  parameter int unsigned OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    seq_start,
  input  logic                    off_load,
  input  logic [OFF_W-1:0]        off_val,
  input  logic                    data_store,
  input  logic [7:0]              byte_val,
  output logic [OFF_W-1:0]        offset,
  output logic [PAGE_BYTES-1:0]   mask,
  output logic [PAGE_BYTES*8-1:0] data_flat
);
  logic [7:0] mem [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset <= '0;
      mask   <= '0;
      for (int i = 0; i < int'(PAGE_BYTES); i++) mem[i] <= '0;
    end else begin
      if (seq_start) mask <= '0;
      if (off_load) offset <= off_val;
      if (data_store) begin
        mem[offset]  <= byte_val;
        mask[offset] <= 1'b1;
        offset       <= OFF_W'(next_off(16'(offset), OFF_W));
      end
    end
  end

  for (genvar g = 0; g < int'(PAGE_BYTES); g++) begin : g_flat
    assign data_flat[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/spiw_front.sv
module spiw_front
  import spiw_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = PAGE_BYTES_DEF,
  parameter int unsigned USED_BITS  = USED_BITS_DEF,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W    = USED_BITS - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sck,
  input  logic                    cs_n,
  input  logic                    si,
  output logic                    so,
  output logic                    so_oe,
  output logic                    commit_valid,
  output logic [PAGE_W-1:0]       commit_page,
  output logic [PAGE_BYTES-1:0]   commit_mask,
  output logic [PAGE_BYTES*8-1:0] commit_data
);
  logic             s_si, sck_rise, cs_rise, cs_idle;
  logic             byte_done, mid_byte;
  logic [7:0]       byte_val;
  dec_state_t       dec_state;
  logic             seq_start, off_load, data_store;
  logic [OFF_W-1:0] off_val, wr_offset;

  spiw_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .s_si(s_si), .sck_rise(sck_rise), .cs_rise(cs_rise), .cs_idle(cs_idle)
  );

  spiw_shift u_shift (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .sck_rise(sck_rise), .s_si(s_si),
    .byte_done(byte_done), .byte_val(byte_val), .mid_byte(mid_byte)
  );

  spiw_decode #(.USED_BITS(USED_BITS), .OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .cs_rise(cs_rise),
    .byte_done(byte_done), .byte_val(byte_val), .mid_byte(mid_byte),
    .any_loaded(|commit_mask), .state(dec_state), .seq_start(seq_start),
    .off_load(off_load), .off_val(off_val), .data_store(data_store),
    .page(commit_page), .commit_valid(commit_valid)
  );

  spiw_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .off_load(off_load),
    .off_val(off_val), .data_store(data_store), .byte_val(byte_val),
    .offset(wr_offset), .mask(commit_mask), .data_flat(commit_data)
  );

  assign so    = 1'b0;
  assign so_oe = 1'b0;
endmodule

// File: rtl/spiw_chk.sv
module spiw_chk
  import spiw_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned OFF_W      = 6,
  parameter int unsigned PAGE_W     = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_idle,
  input logic                  cs_rise,
  input logic                  mid_byte,
  input logic                  data_store,
  input dec_state_t            state,
  input logic [OFF_W-1:0]      offset,
  input logic [PAGE_BYTES-1:0] mask,
  input logic [PAGE_W-1:0]     page,
  input logic                  commit_valid
);
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !commit_valid); // R7
  AST_COMMIT_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(cs_rise)); // R7
  AST_COMMIT_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> ($past(!mid_byte) && (mask != '0))); // R8
  AST_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !mid_byte); // R11
  AST_OFFSET_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    data_store |=> (offset == OFF_W'($past(offset) + 1'b1))); // R5
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    data_store |=> mask[$past(offset)]); // R6
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DEC_LOAD) |=> $stable(page)); // R3
endmodule

bind spiw_front spiw_chk #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .cs_rise(cs_rise), .mid_byte(mid_byte),
  .data_store(data_store), .state(dec_state), .offset(wr_offset), .mask(commit_mask),
  .page(commit_page), .commit_valid(commit_valid)
);

// File: tb/sim_spiw_front.sv
`timescale 1ns/1ps
module sim_spiw_front;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, commit_valid;
  logic [8:0]   commit_page;
  logic [63:0]  commit_mask;
  logic [511:0] commit_data;

  spiw_front u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
    .commit_valid(commit_valid), .commit_page(commit_page),
    .commit_mask(commit_mask), .commit_data(commit_data)
  );

  int vectors = 0, miscompares = 0;
  int commits_seen = 0, commits_exp = 0;
  bit exp_commit = 0, cv_prev = 0;
  logic [7:0]  exp_mem [64];
  logic [63:0] exp_mask;
  logic [8:0]  exp_page;
  string cur_req = "R2";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Per-clock reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(so_oe == 1'b0, "R9", "so_oe", 64'(so_oe), 64'd0);
      if (commit_valid) begin
        int bad = 0;
        chk(!cv_prev, "R7", "strobe width", 64'd2, 64'd1);
        chk(exp_commit, cur_req, "unexpected commit", 64'd1, 64'(exp_commit));
        commits_seen++;
        chk(commit_page == exp_page, "R3", "page", 64'(commit_page), 64'(exp_page));
        chk(commit_mask == exp_mask, "R6", "mask", commit_mask, exp_mask);
        for (int i = 0; i < 64; i++)
          if (exp_mask[i] && commit_data[i*8 +: 8] !== exp_mem[i]) bad++;
        chk(bad == 0, "R4", "bad data bytes (R5 wrap)", 64'(bad), 64'd0);
      end
      cv_prev = commit_valid;
    end
  end

  task automatic spi_bit(input bit b);
    sck = 1'b0; si = b;
    repeat (2) @(negedge clk);
    sck = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_seq(input bit mode3, input logic [7:0] q[$], input int nbits,
                         input string req);
    logic [5:0] off;
    cur_req = req;
    exp_commit = (q[0] == 8'h02) && (nbits >= 32) && (nbits % 8 == 0);
    if (exp_commit) begin
      exp_page = 9'(({q[1], q[2]} & 16'h7FFF) >> 6);
      off = q[2][5:0];
      exp_mask = '0;
      for (int j = 3; j < nbits / 8; j++) begin
        exp_mem[off] = q[j];
        exp_mask[off] = 1'b1;
        off = off + 6'd1;
      end
    end
    @(negedge clk);
    sck = mode3;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < nbits; k++) spi_bit(q[k / 8][7 - (k % 8)]);
    if (!mode3) sck = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
    commits_exp += int'(exp_commit);
    repeat (8) @(negedge clk);
    chk(commits_seen == commits_exp, req, "commit count", 64'(commits_seen), 64'(commits_exp));
    exp_commit = 1'b0;
  endtask

  function automatic void build(ref logic [7:0] q[$], input logic [7:0] op,
                                input logic [15:0] addr, input int n, input int seed);
    q.delete();
    q.push_back(op);
    q.push_back(addr[15:8]);
    q.push_back(addr[7:0]);
    for (int i = 0; i < n; i++) q.push_back(8'((seed + i * 37) ^ (i >> 1)));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R7 watchdog actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(commit_valid == 1'b0, "R1", "commit_valid after reset", 64'(commit_valid), 64'd0);
    chk(so_oe == 1'b0, "R1", "so_oe after reset", 64'(so_oe), 64'd0);

    build(q, 8'h02, 16'h1234, 3, 8'h5A);
    run_seq(1'b0, q, 8 * q.size(), "R4");          // mode 0 basic write
    build(q, 8'h02, 16'h8F3E, 4, 8'hC3);
    run_seq(1'b1, q, 8 * q.size(), "R10");         // mode 3, A15 set, wrap 62..1 (R3 R5)
    build(q, 8'h02, 16'h7FCA, 70, 8'h11);
    run_seq(1'b0, q, 8 * q.size(), "R5");          // overwrite after fold-back
    build(q, 8'h03, 16'h0100, 4, 8'h22);
    run_seq(1'b0, q, 8 * q.size(), "R2");          // wrong command byte
    build(q, 8'h02, 16'h0240, 0, 8'h33);
    run_seq(1'b1, q, 24, "R8");                    // release right after address
    build(q, 8'h02, 16'h0480, 3, 8'h44);
    run_seq(1'b0, q, 24 + 16 + 3, "R8");           // release mid data byte
    build(q, 8'h02, 16'h0480, 1, 8'h55);
    run_seq(1'b0, q, 3, "R11");                    // abort inside command byte
    build(q, 8'h02, 16'h3001, 2, 8'h66);
    run_seq(1'b0, q, 8 * q.size(), "R11");         // clean sequence after abort
    build(q, 8'h02, 16'h0000, 64, 8'h77);
    run_seq(1'b1, q, 8 * q.size(), "R6");          // full page, mode 3
    chk(commit_valid == 1'b0, "R7", "idle after commit", 64'(commit_valid), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule